// File: doc/BRIEF.md
# Protected System Clock Control Registers

This block holds the two byte-wide control registers that steer a chip's system clock tree. The first register picks the clock output pin source and the system clock source. It also holds the wait-mode peripheral clock stop, the sub-oscillator enable, its drive strength, the main-oscillator stop and the fixed divide-by-8 select. The second register carries the main-oscillator drive strength, a two-bit divider select and the request that stops every clock. Each field leaves the block as its own decoded output, which feeds the oscillator and divider logic.

Software reaches both registers over a simple byte bus with an address, a write strobe, write data and combinational read data. A write lands only while an external protect bit is high; reads are always open. Some writes and some power-mode transitions force certain bits to 1 by themselves. These are the slow-divide and strong-drive bits that must be safe whenever the main oscillator is stopped or the part leaves a fast mode. Mode transitions arrive as single-cycle pulses.

Top module: `clkctl_regs`

## Requirements
- R1: After reset, the register at address 6 (REG_A) reads 0x48 and the register at address 7 (REG_B) reads 0x20.
- R2: A write while `prot_en` is 0 changes neither register.
- R3: A write while `prot_en` is 1 stores the write data into the addressed register on the next clock edge, apart from the bits that R4, R5 and R8 force.
- R4: A write to REG_A with data bit 5 (main-oscillator stop) set to 1 forces REG_A bit 6 (divide-by-8) and REG_B bit 5 (main drive strength) to 1 in the same update, even when the write data clears them.
- R5: A write to REG_A with data bit 4 (sub-oscillator enable) equal to 0 forces REG_A bit 3 (sub drive strength) to 1 in the same update.
- R6: A pulse on `evt_to_stop` or on `evt_to_lowpwr` sets REG_A bit 6 and REG_B bit 5 to 1 on the next edge. If it coincides with a write that clears those bits, the forced value wins.
- R7: A pulse on `evt_to_lowspeed` leaves both registers unchanged.
- R8: REG_B bits 4 to 1 always read 0, and any 1 written to them is discarded.
- R9: The decoded outputs follow the register bits. REG_A: [1:0] clock-out select, [2] wait peripheral stop, [3] sub drive, [4] sub-oscillator enable, [5] main stop, [6] divide-by-8, [7] system clock select. REG_B: [0] stop request, [5] main drive, [7:6] divider select.
- R10: Reads do not depend on `prot_en`. A read of any address other than 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| prot_en | input | 1 | Write permission from protect register bit 0 |
| evt_to_stop | input | 1 | Pulse: fast mode to stop mode |
| evt_to_lowpwr | input | 1 | Pulse: fast mode to low-power mode |
| evt_to_lowspeed | input | 1 | Pulse: fast mode to low-speed mode |
| clkout_sel | output | 2 | Clock output pin source |
| wait_periph_stop | output | 1 | Stop peripheral clock in wait |
| sub_drive_hi | output | 1 | Sub-oscillator strong drive |
| sub_osc_en | output | 1 | Sub-oscillator pins enabled |
| main_osc_stop | output | 1 | Main oscillator stopped |
| div8_sel | output | 1 | Fixed divide-by-8 |
| sys_clk_sel | output | 1 | System clock from sub-oscillator |
| main_drive_hi | output | 1 | Main oscillator strong drive |
| div_sel | output | 2 | Divider select |
| stop_req | output | 1 | All-clock stop request |

## Verification
A software write and a mode-transition pulse can land in the same clock cycle. Both then drive the divide-by-8 and main-drive bits. The bench provokes this by raising `evt_to_lowpwr` in the same cycle as a REG_A write that clears bit 6. It also raises `evt_to_stop` in the same cycle as a REG_B write that clears bit 5. The outcome is judged by reading both registers afterwards: the forced 1 must have beaten the written 0, and every other written bit must have landed.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef struct packed {
      logic       sys_sel;
      logic       div8;
      logic       main_stop;
      logic       sub_en;
      logic       sub_drv;
      logic       wait_stop;
      logic [1:0] cko_sel;
   } rega_t;

   typedef struct packed {
      logic [1:0] div_sel;
      logic       main_drv;
      logic [3:0] rsvd;
      logic       stop_req;
   } regb_t;

   localparam logic [BYTE_W-1:0] REGA_RST  = 8'h48;
   localparam logic [BYTE_W-1:0] REGB_RST  = 8'h20;
   localparam logic [BYTE_W-1:0] REGB_RSVD = 8'h1E;
   localparam int unsigned       REGB_DRV_BIT = 5;
endpackage

// File: rtl/clkctl_wdec.sv
module clkctl_wdec #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned A_ADDR = 6,
   parameter int unsigned B_ADDR = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              prot,
   output logic              wr_a,
   output logic              wr_b,
   output logic              sel_a,
   output logic              sel_b
);
   localparam logic [ADDR_W-1:0] A_ENC = ADDR_W'(A_ADDR);
   localparam logic [ADDR_W-1:0] B_ENC = ADDR_W'(B_ADDR);

   always_comb begin
      sel_a = (addr == A_ENC);
      sel_b = (addr == B_ENC);
      wr_a  = we && prot && sel_a;
      wr_b  = we && prot && sel_b;
   end
endmodule

// File: rtl/clkctl_rega.sv
module clkctl_rega
   import clkctl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  rega_t wr_val,
   input  logic  evt_force,
   output rega_t q
);
   rega_t nxt;

   always_comb begin
      nxt = q;
      if (wr_en) begin
         nxt = wr_val;
         if (wr_val.main_stop) nxt.div8 = 1'b1;
         if (!wr_val.sub_en)   nxt.sub_drv = 1'b1;
      end
      if (evt_force) nxt.div8 = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= rega_t'(REGA_RST);
      else        q <= nxt;
   end

   // R5
   sub_drv_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_val.sub_en) |=> q.sub_drv);
endmodule

// File: rtl/clkctl_regb.sv
module clkctl_regb
   import clkctl_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RSVD_MASK = REGB_RSVD,
   parameter logic [BYTE_W-1:0] RST_VAL   = REGB_RST
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  regb_t wr_val,
   input  logic  drv_force,
   output regb_t q
);
   logic [BYTE_W-1:0] nxt;
   logic [BYTE_W-1:0] q_bits;

   always_comb begin
      nxt = q_bits;
      if (wr_en)     nxt = wr_val;
      if (drv_force) nxt[REGB_DRV_BIT] = 1'b1;
   end

   for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      if (RSVD_MASK[b]) begin : g_rsvd
         assign q_bits[b] = 1'b0;
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_bits[b] <= RST_VAL[b];
            else        q_bits[b] <= nxt[b];
         end
      end
   end

   assign q = regb_t'(q_bits);
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned A_ADDR = 6,
   parameter int unsigned B_ADDR = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              prot_en,
   input  logic              evt_to_stop,
   input  logic              evt_to_lowpwr,
   input  logic              evt_to_lowspeed,
   output logic [1:0]        clkout_sel,
   output logic              wait_periph_stop,
   output logic              sub_drive_hi,
   output logic              sub_osc_en,
   output logic              main_osc_stop,
   output logic              div8_sel,
   output logic              sys_clk_sel,
   output logic              main_drive_hi,
   output logic [1:0]        div_sel,
   output logic              stop_req
);
   if (A_ADDR == B_ADDR) begin : g_bad_overlap
      $error("clkctl_regs: register addresses overlap");
   end
   if (A_ADDR >= (1 << ADDR_W) || B_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("clkctl_regs: address outside bus range");
   end

   logic  wr_a, wr_b, sel_a, sel_b, evt_force, drv_force;
   rega_t ra;
   regb_t rb;

   clkctl_wdec #(.ADDR_W(ADDR_W), .A_ADDR(A_ADDR), .B_ADDR(B_ADDR)) u_wdec (
      .addr(bus_addr), .we(bus_we), .prot(prot_en),
      .wr_a(wr_a), .wr_b(wr_b), .sel_a(sel_a), .sel_b(sel_b)
   );

   assign evt_force = evt_to_stop || evt_to_lowpwr;
   assign drv_force = evt_force || (wr_a && bus_wdata[5]);

   clkctl_rega u_rega (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .wr_val(rega_t'(bus_wdata)),
      .evt_force(evt_force), .q(ra)
   );

   clkctl_regb u_regb (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .wr_val(regb_t'(bus_wdata)),
      .drv_force(drv_force), .q(rb)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_a)      bus_rdata = ra;
      else if (sel_b) bus_rdata = rb;
   end

   assign clkout_sel       = ra.cko_sel;
   assign wait_periph_stop = ra.wait_stop;
   assign sub_drive_hi     = ra.sub_drv;
   assign sub_osc_en       = ra.sub_en;
   assign main_osc_stop    = ra.main_stop;
   assign div8_sel         = ra.div8;
   assign sys_clk_sel      = ra.sys_sel;
   assign main_drive_hi    = rb.main_drv;
   assign div_sel          = rb.div_sel;
   assign stop_req         = rb.stop_req;

   // R2
   prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(prot_en && bus_we) && !evt_to_stop && !evt_to_lowpwr) |=> ($stable(ra) && $stable(rb)));

   // R4
   main_stop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_en && bus_we && bus_addr == ADDR_W'(A_ADDR) && bus_wdata[5]) |=> (div8_sel && main_drive_hi));

   // R6
   mode_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_to_stop || evt_to_lowpwr) |=> (div8_sel && main_drive_hi));

   // R7
   lowspeed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_to_lowspeed && !bus_we && !evt_to_stop && !evt_to_lowpwr) |=> ($stable(ra) && $stable(rb)));

   // R8
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(B_ADDR)) |-> (bus_rdata[4:1] == 4'b0000));
endmodule

// File: tb/clkctl_regs_bench.sv
module clkctl_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       prot_en = 1'b0, evt_to_stop = 1'b0, evt_to_lowpwr = 1'b0, evt_to_lowspeed = 1'b0;
   logic [1:0] clkout_sel, div_sel;
   logic wait_periph_stop, sub_drive_hi, sub_osc_en, main_osc_stop, div8_sel, sys_clk_sel;
   logic main_drive_hi, stop_req;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clkctl_regs u_clkctl_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .prot_en(prot_en), .evt_to_stop(evt_to_stop),
      .evt_to_lowpwr(evt_to_lowpwr), .evt_to_lowspeed(evt_to_lowspeed),
      .clkout_sel(clkout_sel), .wait_periph_stop(wait_periph_stop), .sub_drive_hi(sub_drive_hi),
      .sub_osc_en(sub_osc_en), .main_osc_stop(main_osc_stop), .div8_sel(div8_sel),
      .sys_clk_sel(sys_clk_sel), .main_drive_hi(main_drive_hi), .div_sel(div_sel),
      .stop_req(stop_req)
   );

   // {prot, addr, wdata, expected A, expected B}
   localparam logic [28:0] VEC [12] = '{
      {1'b1, 4'd6, 8'h00, 8'h08, 8'h20},   // R5, R3
      {1'b0, 4'd6, 8'hFF, 8'h08, 8'h20},   // R2
      {1'b1, 4'd7, 8'hFF, 8'h08, 8'hE1},   // R8
      {1'b1, 4'd7, 8'h00, 8'h08, 8'h00},   // R3
      {1'b1, 4'd6, 8'h93, 8'h93, 8'h00},   // R3
      {1'b1, 4'd6, 8'h20, 8'h68, 8'h20},   // R4, R5
      {1'b0, 4'd7, 8'hC0, 8'h68, 8'h20},   // R2
      {1'b1, 4'd7, 8'hC0, 8'h68, 8'hC0},   // R3
      {1'b1, 4'd6, 8'h17, 8'h17, 8'hC0},   // R3
      {1'b1, 4'd3, 8'hFF, 8'h17, 8'hC0},   // R10 unmapped write
      {1'b1, 4'd6, 8'h34, 8'h74, 8'hE0},   // R4
      {1'b0, 4'd6, 8'h00, 8'h74, 8'hE0}    // R2
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0; prot_en = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic wr(input logic p, input logic [3:0] a, input logic [7:0] d,
                     input logic e_stop, input logic e_lp, input logic e_ls);
      @(negedge clk);
      prot_en = p; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      evt_to_stop = e_stop; evt_to_lowpwr = e_lp; evt_to_lowspeed = e_ls;
      @(negedge clk);
      bus_we = 1'b0; prot_en = 1'b0;
      evt_to_stop = 1'b0; evt_to_lowpwr = 1'b0; evt_to_lowspeed = 1'b0;
   endtask

   task automatic pulse(input logic e_stop, input logic e_lp, input logic e_ls);
      @(negedge clk);
      evt_to_stop = e_stop; evt_to_lowpwr = e_lp; evt_to_lowspeed = e_ls;
      @(negedge clk);
      evt_to_stop = 1'b0; evt_to_lowpwr = 1'b0; evt_to_lowspeed = 1'b0;
   endtask

   task automatic both(input string req, input logic [7:0] ea, input logic [7:0] eb);
      logic [7:0] d;
      rd(4'd6, d); chk(req, d, ea);
      rd(4'd7, d); chk(req, d, eb);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      both("R1 reset", 8'h48, 8'h20);
      chk("R9 reset stop_req", {7'b0, stop_req}, 8'h00);

      foreach (VEC[i]) begin
         wr(VEC[i][28], VEC[i][27:24], VEC[i][23:16], 1'b0, 1'b0, 1'b0);
         both("R3 table", VEC[i][15:8], VEC[i][7:0]);
         // R9 decoded fields
         chk("R9 fields A", {sys_clk_sel, div8_sel, main_osc_stop, sub_osc_en, sub_drive_hi,
                             wait_periph_stop, clkout_sel}, VEC[i][15:8]);
         chk("R9 fields B", {div_sel, main_drive_hi, 4'b0000, stop_req}, VEC[i][7:0]);
      end

      // R10: unmapped read returns zero
      rd(4'd3, d); chk("R10 unmapped read", d, 8'h00);

      // R6: stop event alone
      wr(1'b1, 4'd7, 8'h00, 1'b0, 1'b0, 1'b0);
      wr(1'b1, 4'd6, 8'h10, 1'b0, 1'b0, 1'b0);
      both("R6 pre", 8'h10, 8'h00);
      pulse(1'b1, 1'b0, 1'b0);
      both("R6 stop event", 8'h50, 8'h20);

      // R6: low-power event coincides with write clearing bit 6
      wr(1'b1, 4'd7, 8'h00, 1'b0, 1'b0, 1'b0);
      wr(1'b1, 4'd6, 8'h10, 1'b0, 1'b1, 1'b0);
      both("R6 lowpwr+write", 8'h50, 8'h20);

      // R6: stop event coincides with write clearing REG_B bit 5
      wr(1'b1, 4'd7, 8'h40, 1'b1, 1'b0, 1'b0);
      both("R6 stop+write B", 8'h50, 8'h60);

      // R7: low-speed event changes nothing
      wr(1'b1, 4'd7, 8'h00, 1'b0, 1'b0, 1'b0);
      wr(1'b1, 4'd6, 8'h10, 1'b0, 1'b0, 1'b0);
      pulse(1'b0, 1'b0, 1'b1);
      both("R7 lowspeed", 8'h10, 8'h00);

      // R9: stop request output
      wr(1'b1, 4'd7, 8'h01, 1'b0, 1'b0, 1'b0);
      chk("R9 stop_req", {7'b0, stop_req}, 8'h01);

      // R1: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      both("R1 re-reset", 8'h48, 8'h20);

      summary();
   end
endmodule